// File: doc/BRIEF.md
# Memory-Card Boot Partition Locator

This block examines the first sector of a memory card as it streams past, one byte per strobe with its offset alongside, and works out where a numbered boot image starts on the card. It reads the four primary partition slots of the partition table near the end of the sector and looks for the slot whose type byte marks a raw boot-image partition (0xA2). The boot images sit one after another inside that partition, 64 KB apart. Sector offsets in the range 0x000–0x1BD are code and play no part in the result.

If the closing two-byte signature is missing, the card is treated as having no partition table. The block then reports raw mode, and the images start at sector 0. If the signature is present but no slot carries the boot type, the block raises a not-found error instead. All addresses are in 512-byte sectors, so each image step adds 128 sectors. The result is latched when byte 0x1FF arrives. The start sector then follows the requested image number combinationally until the next sector begins.

The controller has three states. ST_IDLE waits after reset. ST_COLLECT captures fields while bytes arrive. ST_DONE holds the result. The transitions are:
- start: ST_IDLE to ST_COLLECT on a byte at offset 0.
- finish: ST_COLLECT to ST_DONE on the byte at offset 0x1FF.
- restart: ST_COLLECT or ST_DONE back to ST_COLLECT on a byte at offset 0.

Top module: `mbr_boot_locator`

## Requirements
- R1: After reset, result_valid is 0 and start_sector, part_size, raw_mode and not_found are all 0.
- R2: A strobed byte at offset 0 begins a new sector and clears all captured fields. From the next cycle, result_valid is 0 until that sector's byte 0x1FF has been taken.
- R3: result_valid is 0 on the cycle that byte 0x1FF is strobed and 1 from the following cycle. It stays 1 until the next offset-0 byte. A byte 0x1FF strobed while no sector is open (from ST_IDLE) is ignored.
- R4: The signature is valid when offset 0x1FE holds 0x55 and offset 0x1FF holds 0xAA. Otherwise the result is raw mode: raw_mode=1, not_found=0, part_size=0 and start_sector = image_sel × 128.
- R5: Slot i (0..3) occupies offsets 0x1BE+16·i to 0x1BE+16·i+15, with the type at slot byte 4, the first sector at bytes 8–11 and the sector count at bytes 12–15, both little-endian. When the signature is valid and a slot has type 0xA2, raw_mode=0, not_found=0, part_size is that slot's count and start_sector = first sector + image_sel × 128 (modulo 2^32).
- R6: When several slots carry type 0xA2, the lowest-numbered one is used.
- R7: With a valid signature and no slot of type 0xA2, not_found=1, raw_mode=0, start_sector=0 and part_size=0.
- R8: Code bytes at 0x000–0x1BD, the boot indicator at slot byte 0 (including 0x80) and the other slot bytes have no effect on the result.
- R9: While result_valid is 1, a change of image_sel moves start_sector in the same cycle, with no new sector needed.
- R10: While result_valid is 0, start_sector, part_size, raw_mode and not_found are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | Strobe: a sector byte is present this cycle |
| byte_offset | input | 9 | Offset of the byte within the sector |
| byte_data | input | 8 | Sector byte |
| image_sel | input | 2 | Requested boot image number |
| result_valid | output | 1 | Result for the last full sector is available |
| start_sector | output | 32 | Start sector of the requested image |
| raw_mode | output | 1 | No partition table; images are placed from sector 0 |
| part_size | output | 32 | Sector count of the boot partition |
| not_found | output | 1 | Table present but no boot-type slot |

## Verification
On every cycle the assertions check several fixed relations:
- raw mode and not-found never appear together;
- the outputs are quiet whenever no result is held;
- a raw result always equals image_sel × 128 with zero size;
- the step from the partition base stays fixed while image_sel moves;
- an offset-0 byte drops the result;
- the closing byte raises the result one cycle later.

Which slot wins, the little-endian assembly of the first-sector and count fields, and the wrap of the address sum depend on the sector contents. Only the bench's scenarios can show these: a sweep over all sixteen patterns of boot-type slots, damaged signatures, code areas full of lookalike bytes and an address near 2^32.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
    localparam int TYPE_REL    = 4;
    localparam int LBA_REL     = 8;
    localparam int CNT_REL     = 12;
    localparam int FIELD_BYTES = 4;
    localparam int FIELD_W     = 8 * FIELD_BYTES;

    typedef struct packed {
        logic [7:0]         ptype;
        logic [FIELD_W-1:0] lba;
        logic [FIELD_W-1:0] cnt;
    } part_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_DONE
    } loc_state_t;
endpackage

// File: rtl/mbr_entry_capture.sv
module mbr_entry_capture
    import mbr_pkg::*;
#(
    parameter int OFS_W       = 9,
    parameter int BASE        = 446,
    parameter int ENTRY_BYTES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] ofs,
    input  logic [7:0]       data,
    output part_entry_t      entry
);
    localparam logic [OFS_W-1:0] BASE_O = BASE[OFS_W-1:0];
    localparam logic [OFS_W-1:0] END_O  = BASE_O + ENTRY_BYTES[OFS_W-1:0];
    localparam logic [OFS_W-1:0] TYPE_O = TYPE_REL[OFS_W-1:0];
    localparam logic [OFS_W-1:0] LBA_O  = LBA_REL[OFS_W-1:0];
    localparam logic [OFS_W-1:0] CNT_O  = CNT_REL[OFS_W-1:0];

    logic             hit;
    logic [OFS_W-1:0] rel;

    assign hit = (ofs >= BASE_O) && (ofs < END_O);
    assign rel = ofs - BASE_O;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry <= '0;
        end else if (clear) begin
            entry <= '0;
        end else if (wr_en && hit) begin
            if (rel == TYPE_O) begin
                entry.ptype <= data;
            end
            for (int b = 0; b < FIELD_BYTES; b++) begin
                if (rel == LBA_O + OFS_W'(b)) begin
                    entry.lba[8*b +: 8] <= data;
                end
                if (rel == CNT_O + OFS_W'(b)) begin
                    entry.cnt[8*b +: 8] <= data;
                end
            end
        end
    end
endmodule

// File: rtl/mbr_match_select.sv
module mbr_match_select
    import mbr_pkg::*;
#(
    parameter int         NUM_ENTRIES = 4,
    parameter logic [7:0] BOOT_TYPE   = 8'hA2
) (
    input  part_entry_t        entries [NUM_ENTRIES],
    output logic               found,
    output logic [FIELD_W-1:0] sel_lba,
    output logic [FIELD_W-1:0] sel_cnt
);
    // Walk from the highest slot down so the lowest match is written last.
    always_comb begin
        found   = 1'b0;
        sel_lba = '0;
        sel_cnt = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (entries[i].ptype == BOOT_TYPE) begin
                found   = 1'b1;
                sel_lba = entries[i].lba;
                sel_cnt = entries[i].cnt;
            end
        end
    end
endmodule

// File: rtl/mbr_image_addr.sv
module mbr_image_addr #(
    parameter int ADDR_W         = 32,
    parameter int SEL_W          = 2,
    parameter int STRIDE_SECTORS = 128
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [SEL_W-1:0]  sel,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(STRIDE_SECTORS);

    assign addr = base + ADDR_W'(sel) * STRIDE;
endmodule

// File: rtl/mbr_boot_locator.sv
module mbr_boot_locator
    import mbr_pkg::*;
#(
    parameter int         SECTOR_BYTES   = 512,
    parameter int         NUM_ENTRIES    = 4,
    parameter int         TABLE_BASE     = 446,
    parameter int         ENTRY_BYTES    = 16,
    parameter logic [7:0] BOOT_TYPE      = 8'hA2,
    parameter logic [7:0] SIG_LO         = 8'h55,
    parameter logic [7:0] SIG_HI         = 8'hAA,
    parameter int         STRIDE_SECTORS = 128,
    parameter int         SEL_W          = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        byte_valid,
    input  logic [$clog2(SECTOR_BYTES)-1:0] byte_offset,
    input  logic [7:0]                  byte_data,
    input  logic [SEL_W-1:0]            image_sel,
    output logic                        result_valid,
    output logic [FIELD_W-1:0]          start_sector,
    output logic                        raw_mode,
    output logic [FIELD_W-1:0]          part_size,
    output logic                        not_found
);
    localparam int               OFS_W      = $clog2(SECTOR_BYTES);
    localparam logic [OFS_W-1:0] LAST_OFS   = OFS_W'(SECTOR_BYTES - 1);
    localparam logic [OFS_W-1:0] SIG_LO_OFS = OFS_W'(SECTOR_BYTES - 2);

    loc_state_t state, next_state;

    logic               is_first, is_last, collecting, wr_en;
    logic               sig_lo_seen, sig_ok;
    logic               found;
    logic [FIELD_W-1:0] sel_lba, sel_cnt, img_addr;
    logic               res_raw, res_nf;
    logic [FIELD_W-1:0] res_base, res_size;
    part_entry_t        entries [NUM_ENTRIES];

    assign is_first   = byte_valid && (byte_offset == '0);
    assign is_last    = byte_valid && (byte_offset == LAST_OFS);
    assign collecting = (state == ST_COLLECT);
    assign wr_en      = byte_valid && collecting;
    assign sig_ok     = sig_lo_seen && (byte_data == SIG_HI);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_ENTRIES; gi++) begin : g_slot
            mbr_entry_capture #(
                .OFS_W      (OFS_W),
                .BASE       (TABLE_BASE + gi * ENTRY_BYTES),
                .ENTRY_BYTES(ENTRY_BYTES)
            ) u_cap (
                .clk  (clk),
                .rst_n(rst_n),
                .clear(is_first),
                .wr_en(wr_en),
                .ofs  (byte_offset),
                .data (byte_data),
                .entry(entries[gi])
            );
        end
    endgenerate

    mbr_match_select #(
        .NUM_ENTRIES(NUM_ENTRIES),
        .BOOT_TYPE  (BOOT_TYPE)
    ) u_sel (
        .entries(entries),
        .found  (found),
        .sel_lba(sel_lba),
        .sel_cnt(sel_cnt)
    );

    mbr_image_addr #(
        .ADDR_W        (FIELD_W),
        .SEL_W         (SEL_W),
        .STRIDE_SECTORS(STRIDE_SECTORS)
    ) u_addr (
        .base(res_base),
        .sel (image_sel),
        .addr(img_addr)
    );

    // Signature low byte tracker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_lo_seen <= 1'b0;
        end else if (is_first) begin
            sig_lo_seen <= 1'b0;
        end else if (wr_en && byte_offset == SIG_LO_OFS) begin
            sig_lo_seen <= (byte_data == SIG_LO);
        end
    end

    // Next-state logic
    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE:    if (is_first) next_state = ST_COLLECT;
            ST_COLLECT: if (is_first) next_state = ST_COLLECT;
                        else if (is_last) next_state = ST_DONE;
            ST_DONE:    if (is_first) next_state = ST_COLLECT;
            default:    next_state = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= next_state;
        end
    end

    // Result register, loaded on the finish transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_raw  <= 1'b0;
            res_nf   <= 1'b0;
            res_base <= '0;
            res_size <= '0;
        end else if (collecting && is_last) begin
            res_raw  <= !sig_ok;
            res_nf   <= sig_ok && !found;
            res_base <= (sig_ok && found) ? sel_lba : '0;
            res_size <= (sig_ok && found) ? sel_cnt : '0;
        end
    end

    // Output drive
    always_comb begin
        result_valid = (state == ST_DONE);
        raw_mode     = result_valid && res_raw;
        not_found    = result_valid && res_nf;
        part_size    = result_valid ? res_size : '0;
        start_sector = (result_valid && !res_nf) ? img_addr : '0;
    end
endmodule

// File: rtl/mbr_boot_locator_chk.sv
module mbr_boot_locator_chk #(
    parameter int OFS_W          = 9,
    parameter int SEL_W          = 2,
    parameter int STRIDE_SECTORS = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_valid,
    input logic [OFS_W-1:0] byte_offset,
    input logic [SEL_W-1:0] image_sel,
    input logic             collecting,
    input logic             result_valid,
    input logic [31:0]      start_sector,
    input logic             raw_mode,
    input logic [31:0]      part_size,
    input logic             not_found
);
    localparam logic [OFS_W-1:0] LAST_OFS = '1;
    localparam logic [31:0]      STRIDE   = 32'(STRIDE_SECTORS);

    logic [31:0] sel_step;
    assign sel_step = 32'(image_sel) * STRIDE;

    AST_FINISH_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (collecting && byte_valid && byte_offset == LAST_OFS) |=> result_valid); // R3

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_offset == '0) |=> !result_valid); // R2

    AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(raw_mode && not_found)); // R7

    AST_RAW_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        raw_mode |-> (start_sector == sel_step && part_size == 32'd0)); // R4

    AST_NOT_FOUND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        not_found |-> (start_sector == 32'd0 && part_size == 32'd0)); // R7

    AST_QUIET_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> (start_sector == 32'd0 && part_size == 32'd0
                           && !raw_mode && !not_found)); // R10

    AST_BASE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && $past(result_valid) && !not_found)
        |-> ((start_sector - sel_step) == $past(start_sector - sel_step))); // R9
endmodule

bind mbr_boot_locator mbr_boot_locator_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_valid  (byte_valid),
    .byte_offset (byte_offset),
    .image_sel   (image_sel),
    .collecting  (collecting),
    .result_valid(result_valid),
    .start_sector(start_sector),
    .raw_mode    (raw_mode),
    .part_size   (part_size),
    .not_found   (not_found)
);

// File: tb/mbr_boot_locator_tb.sv
module mbr_boot_locator_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        byte_valid;
    logic [8:0]  byte_offset;
    logic [7:0]  byte_data;
    logic [1:0]  image_sel;
    logic        result_valid;
    logic [31:0] start_sector;
    logic        raw_mode;
    logic [31:0] part_size;
    logic        not_found;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    logic [7:0]  sec [512];
    logic [7:0]  et_type [4];
    logic [7:0]  et_boot [4];
    logic [31:0] et_lba  [4];
    logic [31:0] et_cnt  [4];

    always #4 clk = ~clk;

    mbr_boot_locator u_dut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid),
        .byte_offset(byte_offset), .byte_data(byte_data),
        .image_sel(image_sel), .result_valid(result_valid),
        .start_sector(start_sector), .raw_mode(raw_mode),
        .part_size(part_size), .not_found(not_found)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        byte_valid = 1'b0; byte_offset = '0; byte_data = '0; image_sel = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic default_entries();
        for (int i = 0; i < 4; i++) begin
            et_type[i] = 8'h83 + 8'(i);
            et_boot[i] = (i == 3) ? 8'h80 : 8'h00;
            et_lba[i]  = 32'h0001_0000 * 32'(i + 1) + 32'h0000_0123 * 32'(i);
            et_cnt[i]  = 32'h0000_4000 + 32'h11 * 32'(i);
        end
    endtask

    task automatic build(input logic [7:0] lo, input logic [7:0] hi, input bit code_a2);
        for (int k = 0; k < 512; k++) sec[k] = code_a2 ? 8'hA2 : (8'(k) ^ 8'h5A);
        for (int i = 0; i < 4; i++) begin
            int b = 446 + 16 * i;
            for (int j = 0; j < 16; j++) sec[b + j] = 8'hC0 + 8'(j);
            sec[b] = et_boot[i];
            sec[b + 4] = et_type[i];
            for (int j = 0; j < 4; j++) begin
                sec[b + 8 + j]  = et_lba[i][8*j +: 8];
                sec[b + 12 + j] = et_cnt[i][8*j +: 8];
            end
        end
        sec[510] = lo;
        sec[511] = hi;
    endtask

    task automatic stream();
        for (int k = 0; k < 512; k++) begin
            @(negedge clk);
            if (k == 511) chk("R3", "valid while last byte strobed", 32'(result_valid), 32'd0);
            byte_valid = 1'b1; byte_offset = 9'(k); byte_data = sec[k];
        end
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    // kind: 0 = partition found, 1 = raw, 2 = not found
    task automatic check_result(input string req, input int kind,
                                input logic [31:0] base, input logic [31:0] size);
        chk("R3", "valid one cycle after last byte", 32'(result_valid), 32'd1);
        for (int s = 0; s < 4; s++) begin
            logic [31:0] exp_start;
            image_sel = 2'(s);
            #1;
            exp_start = (kind == 2) ? 32'd0 : base + 32'(s) * 32'd128;
            chk(req, "start_sector (R9 sel sweep)", start_sector, exp_start);
            chk(req, "part_size", part_size, (kind == 0) ? size : 32'd0);
            chk(req, "raw_mode", 32'(raw_mode), (kind == 1) ? 32'd1 : 32'd0);
            chk(req, "not_found", 32'(not_found), (kind == 2) ? 32'd1 : 32'd0);
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1", "valid", 32'(result_valid), 0);
        chk("R1", "start", start_sector, 0);
        chk("R1", "size", part_size, 0);
        chk("R1", "raw", 32'(raw_mode), 0);
        chk("R1", "nf", 32'(not_found), 0);

        // R3 a lone closing byte from idle is ignored
        @(negedge clk);
        byte_valid = 1'b1; byte_offset = 9'h1FF; byte_data = 8'hAA;
        @(negedge clk);
        byte_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R3", "valid after lone closing byte", 32'(result_valid), 0);
        chk("R10", "start while empty", start_sector, 0);

        // R5 R6 R7 sweep over every pattern of boot-type slots
        for (int m = 0; m < 16; m++) begin
            int win = -1;
            default_entries();
            for (int i = 3; i >= 0; i--) if (m[i]) begin et_type[i] = 8'hA2; win = i; end
            build(8'h55, 8'hAA, 1'b0);
            stream();
            if (win < 0) check_result("R7", 2, 0, 0);
            else check_result(m > 1 ? "R6" : "R5", 0, et_lba[win], et_cnt[win]);
        end

        // R2 offset-0 byte clears the result
        @(negedge clk);
        byte_valid = 1'b1; byte_offset = '0; byte_data = 8'h00;
        @(negedge clk);
        byte_valid = 1'b0;
        chk("R2", "valid after restart", 32'(result_valid), 0);
        chk("R10", "size after restart", part_size, 0);
        chk("R10", "start after restart", start_sector, 0);

        // R4 damaged signatures give raw mode even with a boot slot
        default_entries();
        et_type[1] = 8'hA2;
        build(8'h55, 8'h00, 1'b0);
        stream();
        check_result("R4", 1, 0, 0);
        build(8'hAA, 8'h55, 1'b0);
        stream();
        check_result("R4", 1, 0, 0);

        // R8 code area full of boot-type bytes, no boot slot
        default_entries();
        build(8'h55, 8'hAA, 1'b1);
        stream();
        check_result("R8", 2, 0, 0);

        // R8 boot indicator on a matching slot changes nothing
        default_entries();
        et_type[2] = 8'hA2;
        et_boot[2] = 8'h80;
        build(8'h55, 8'hAA, 1'b1);
        stream();
        check_result("R8", 0, et_lba[2], et_cnt[2]);

        // R5 little-endian fields and address wrap near 2^32
        default_entries();
        et_type[0] = 8'hA2;
        et_lba[0]  = 32'hFFFF_FFA0;
        et_cnt[0]  = 32'h1234_5678;
        build(8'h55, 8'hAA, 1'b0);
        stream();
        check_result("R5", 0, 32'hFFFF_FFA0, 32'h1234_5678);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule